// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

A single-channel timer that sits on a simple register bus and counts down once per clock while enabled. Software sets a start count, a reload value and two enable bits. When the count runs out, the timer refills itself from the reload value on the following clock and latches a pending event. Software acknowledges the event by writing a one to the status word.

With a small reload value the block produces a periodic tick on its level interrupt line. With the reload value at all ones and the interrupt masked, it serves as a free-running, wrapping time base that software samples by reading the count. Read data follows the address combinationally. Writes take effect at the clock edge on which select and write enable are both high.

Top module: `dtimer`

## Requirements
- R1: After reset, the control, count, reload and status words all read 0, and `irq` is low.
- R2: The control word is at offset 0x0. Bit 0 enables counting and bit 3 enables the interrupt. A read returns only those two bits, with every other bit 0.
- R3: The count word is at offset 0x4. A write replaces the count at that edge, and the new value is readable from the next cycle.
- R4: While counting is enabled, the count drops by exactly one per clock. While it is disabled, the count and the reload value hold their values.
- R5: The reload word is at offset 0x8. An enabled count that is 0 at a clock edge takes the reload value at that edge and sets the pending flag. With reload 0, the flag is set on every clock.
- R6: The pending flag is set on expiry whether or not bit 3 is on. `irq` is high exactly when the flag is set and bit 3 is on.
- R7: The status word is at offset 0xC. Bit 0 reads the pending flag and all other bits read 0. Writing a value with bit 0 set clears the flag. Writing a value with bit 0 clear leaves it unchanged.
- R8: When a clear write and an expiry fall on the same edge, the flag remains set.
- R9: When a count write and an expiry fall on the same edge, the written value is loaded.
- R10: An address is unmapped if it has a nonzero bit at position 4 or above, or a nonzero bit 0 or 1. Reads of an unmapped address return 0, and writes to one change nothing.
- R11: With reload at all ones, the count wraps from 0 to 0xFFFFFFFF and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus select |
| wr | input | 1 | Write enable, qualified by sel |
| addr | input | AW (12) | Byte address |
| wdata | input | W (32) | Write data |
| rdata | output | W (32) | Read data for addr |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are the two same-edge collisions: a clear write or a count write landing on exactly the edge where an expiry happens. The stimulus forces both by parking the timer at count 0 with reload 0 and counting enabled, so that every edge is an expiry, and then issues the write. A long random phase also mixes small counts with bus traffic. A bench-side model predicts every read and the `irq` level on each cycle of that phase.

// File: rtl/dtimer.sv
module dtimer #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_RLD = 2'd2, A_STAT = 2'd3;

  logic         en, ie, flag;
  logic [W-1:0] cnt, rld;

  wire        mapped = (addr[AW-1:4] == '0) && (addr[1:0] == 2'b00);
  wire [1:0]  word   = addr[3:2];
  wire        wen    = sel && wr && mapped;
  wire        expire = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      cnt  <= '0;
      rld  <= '0;
      flag <= 1'b0;
    end else begin
      if (wen && word == A_CNT)   cnt <= wdata;
      else if (expire)            cnt <= rld;
      else if (en)                cnt <= cnt - 1'b1;

      if (expire)                                 flag <= 1'b1;
      else if (wen && word == A_STAT && wdata[0]) flag <= 1'b0;

      if (wen && word == A_CTRL) begin
        en <= wdata[0];
        ie <= wdata[3];
      end
      if (wen && word == A_RLD) rld <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (mapped) begin
      unique case (word)
        A_CTRL: begin rdata[0] = en; rdata[3] = ie; end
        A_CNT:  rdata = cnt;
        A_RLD:  rdata = rld;
        A_STAT: rdata[0] = flag;
      endcase
    end
  end

  assign irq = flag & ie;
endmodule

module dtimer_chk #(
  parameter int W  = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          en,
  input logic          flag,
  input logic [W-1:0]  cnt,
  input logic          irq
);
  wire okadr  = (addr[AW-1:4] == '0) && (addr[1:0] == 2'b00);
  wire cnt_wr = sel && wr && okadr && addr[3:2] == 2'd1;
  wire clr_wr = sel && wr && okadr && addr[3:2] == 2'd3 && wdata[0];
  wire at0    = en && cnt == '0;

  p_load_r3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && cnt != '0 && !cnt_wr |=> cnt == $past(cnt) - 1'b1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !cnt_wr |=> $stable(cnt));
  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at0 && !clr_wr |=> flag);
  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at0 && clr_wr |=> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !at0 |=> !flag);
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind dtimer dtimer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .en(en), .flag(flag), .cnt(cnt), .irq(irq)
);

// File: tb/dtimer_test.sv
module dtimer_test;
  localparam int CLK = 10;
  localparam int W = 32, AW = 12;

  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  dtimer #(.W(W), .AW(AW)) uut (.*);

  always #(CLK/2) clk = ~clk;

  logic m_en, m_ie, m_flag;
  logic [W-1:0] m_cnt, m_rld, n_cnt;
  logic n_flag, m_exp, m_hit;

  function automatic bit is_mapped(logic [AW-1:0] a);
    return (a[AW-1:4] == '0) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [W-1:0] exp_rd(logic [AW-1:0] a);
    if (!is_mapped(a)) return '0;
    case (a[3:2])
      2'd0: return {{(W-4){1'b0}}, m_ie, 2'b00, m_en};
      2'd1: return m_cnt;
      2'd2: return m_rld;
      default: return {{(W-1){1'b0}}, m_flag};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_flag = 0; m_cnt = '0; m_rld = '0;
    end else begin
      m_exp  = m_en && m_cnt == '0;
      m_hit  = sel && wr && is_mapped(addr);
      n_cnt  = m_en ? (m_exp ? m_rld : m_cnt - 1) : m_cnt;
      n_flag = m_flag;
      if (m_hit && addr[3:2] == 2'd3 && wdata[0]) n_flag = 0;
      if (m_exp) n_flag = 1;
      if (m_hit && addr[3:2] == 2'd1) n_cnt = wdata;
      if (m_hit && addr[3:2] == 2'd2) m_rld = wdata;
      if (m_hit && addr[3:2] == 2'd0) begin m_en = wdata[0]; m_ie = wdata[3]; end
      m_cnt = n_cnt; m_flag = n_flag;
    end
  end

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(bit s, bit w, logic [AW-1:0] a, logic [W-1:0] d, output logic [W-1:0] got);
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d;
    #1;
    got = rdata;
    if (rst_n) begin
      check({tag, " read"}, rdata, exp_rd(a));
      check({tag, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_flag & m_ie});
    end
    @(posedge clk);
    #1;
    sel = 0; wr = 0;
  endtask

  task automatic put(logic [AW-1:0] a, logic [W-1:0] d);
    logic [W-1:0] g;
    cyc(1, 1, a, d, g);
  endtask

  task automatic get(logic [AW-1:0] a, output logic [W-1:0] g);
    cyc(1, 0, a, '0, g);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    tag = "R1";
    for (int i = 0; i < 4; i++) begin get(AW'(i * 4), v); check("R1 reset", v, '0); end
    check("R1 irq", {31'b0, irq}, '0);

    tag = "R2";
    put('h0, 32'hFFFF_FFFF); get('h0, v); check("R2 ctrl bits", v, 32'h9);
    put('h0, 0);

    tag = "R3";
    put('h4, 5); get('h4, v); check("R3 count write", v, 5);
    tag = "R4";
    repeat (3) get('h8, v);
    get('h4, v); check("R4 hold disabled", v, 5);
    put('h8, 3); put('h0, 1);
    get('h4, v); check("R4 first", v, 5);
    for (int k = 4; k >= 0; k--) begin get('h4, v); check("R4 step", v, W'(k)); end
    tag = "R5";
    get('hC, v); check("R5 flag on expiry", v, 1);
    check("R6 irq masked", {31'b0, irq}, '0);
    get('h4, v); check("R5 reloaded", v, 2);

    tag = "R6";
    put('h0, 9); get('h0, v); check("R6 irq on", {31'b0, irq}, 1);
    put('h0, 8);
    tag = "R7";
    put('hC, 32'hFFFF_FFFE); get('hC, v); check("R7 write0 keeps", v, 1);
    put('hC, 1); get('hC, v); check("R7 w1c", v, 0);
    check("R7 irq low", {31'b0, irq}, '0);

    tag = "R8";
    put('h4, 0); put('h8, 0); put('h0, 1);
    put('hC, 1); get('hC, v); check("R8 clear vs expiry", v, 1);
    tag = "R9";
    put('h8, 7); put('h4, 20); get('h4, v); check("R9 write wins", v, 20);

    tag = "R11";
    put('h0, 0); put('h8, 32'hFFFF_FFFF); put('h4, 1); put('h0, 1);
    get('h4, v); check("R11 start", v, 1);
    get('h4, v); check("R11 zero", v, 0);
    get('h4, v); check("R11 wrap", v, 32'hFFFF_FFFF);
    get('h4, v); check("R11 after wrap", v, 32'hFFFF_FFFE);

    tag = "R10";
    put('h0, 0);
    get('h10, v); check("R10 unmapped read", v, 0);
    get('h6, v);  check("R10 misaligned read", v, 0);
    put('h10, 32'hFFFF_FFFF); put('h5, 123); put('h401, 9);
    get('h0, v); check("R10 ctrl untouched", v, 0);
    get('h8, v); check("R10 reload untouched", v, 32'hFFFF_FFFF);
    get('h4, v); check("R10 count untouched", v, 32'hFFFF_FFFC);

    tag = "R5 R6 R8 R9 random";
    void'($urandom(1234));
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [W-1:0] d;
      int r = $urandom_range(0, 9);
      a = (r == 9) ? AW'($urandom) : AW'($urandom_range(0, 3) * 4);
      d = ($urandom_range(0, 3) == 0) ? $urandom : W'($urandom_range(0, 6));
      if (a == 'hC && $urandom_range(0, 1) == 0) d = 1;
      if (a == 'h0) d = {28'b0, $urandom_range(0, 1) == 1, 2'b00, $urandom_range(0, 3) != 0};
      cyc(1, $urandom_range(0, 2) == 0, a, d, v);
    end

    done = 1;
    summary();
  end
endmodule